// File: doc/BRIEF.md
# Write Enable and Block Protection Controller

This block guards every program cycle of a small serial memory. It keeps a volatile write-enable latch and a two-bit protection level, and from them it assembles the status byte that the serial front-end shifts out on a status read. Its inputs are command pulses already decoded by the front-end, the active-low hardware protect pin, and the busy and done flags of the program sequencer.

The front-end presents a write request, either to the array or to the status byte, in the cycle where chip select rises. In that cycle the block decides whether the request is allowed. An allowed request becomes a one-cycle grant pulse, and that pulse starts the sequencer. A refused request is dropped and changes no state. The protection level chooses an address fence: nothing, the top quarter, the top half, or the whole array. A new level written through a status write only takes effect when that program cycle completes. Every completed program cycle clears the enable latch. While the sequencer is busy, the status byte reads as all ones apart from bit 0, and every command and request is ignored.

Top module: `wp_guard`

## Requirements
- R1: After reset the enable latch is clear, the protection level is 00 and `statusByte` reads 0x00.
- R2: `cmdEnable` sets the enable latch and `cmdDisable` clears it. Both act from the next clock edge and are seen in bit 1 of `statusByte`.
- R3: While not busy, `statusByte` carries 0 in bits 7:4, the protection level in bits 3:2, the enable latch in bit 1 and 0 in bit 0.
- R4: While `progBusy` is high, `statusByte` reads 0xFF, which is ones in bits 7:1 and the busy flag in bit 0.
- R5: An array write request is granted only when `writeProtN` is high, the enable latch is set and the address lies outside the fence. The grant is a one-cycle pulse on `grantArray` in the cycle after the request.
- R6: The fence depends on the level. Level 00 fences nothing, 01 fences 0x180–0x1FF, 10 fences 0x100–0x1FF and 11 fences 0x000–0x1FF.
- R7: A status write request is granted (one-cycle `grantStatus` in the next cycle) when `writeProtN` is high and the latch is set, whatever the level. The level becomes `reqProtBits` (data bits 3:2) at the following `progDone`.
- R8: A `progDone` pulse clears the enable latch.
- R9: A refused request raises no grant and leaves the enable latch and the protection level unchanged.
- R10: While `progBusy` is high, enable, disable and both write requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| writeProtN | input | 1 | Hardware protect pin; low forbids all writes |
| cmdEnable | input | 1 | Decoded enable command pulse |
| cmdDisable | input | 1 | Decoded disable command pulse |
| reqArrayWr | input | 1 | Array write request at chip-select rise |
| reqAddr | input | ADDR_W | Start address of the array write |
| reqStatusWr | input | 1 | Status write request at chip-select rise |
| reqProtBits | input | 2 | Bits 3:2 of the status write data byte |
| progBusy | input | 1 | Sequencer busy flag |
| progDone | input | 1 | Sequencer completion pulse |
| grantArray | output | 1 | Array program cycle permitted |
| grantStatus | output | 1 | Status program cycle permitted |
| statusByte | output | 8 | Byte the front-end shifts out on a status read |

## Verification
The hardest case to reach is a command that arrives while the sequencer is busy with no completion pulse near it. A real completion clears the latch anyway, so an ignored enable or disable would leave no trace. The stimulus therefore raises `progBusy` on its own, with no grant and no `progDone`. It issues enable, disable and write requests during that window, then drops busy and reads the latch through `statusByte`. The deferred level update is covered by checking the status byte only after each completion pulse, with data bytes whose neighbouring bits differ from bits 3:2.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef struct packed {
    logic setWen;
    logic clrWen;
    logic capBp;
    logic commitBp;
  } wpStrobe_t;

  localparam int STS_BUSY_BIT = 0;
  localparam int STS_WEN_BIT  = 1;
  localparam int STS_BP_LO    = 2;
  localparam int STS_BP_HI    = 3;

endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter logic [1:0] BP_RESET = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqProtBits,
  input  logic              progBusy,
  output logic              wenQ,
  output logic              inFence,
  output logic [7:0]        statusByte
);

  localparam logic [ADDR_W-1:0] HALF_BASE    = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] QUARTER_BASE = {2'b11, {(ADDR_W-2){1'b0}}};

  logic [1:0] bpQ;
  logic [1:0] bpPend;
  logic       pendValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wenQ      <= 1'b0;
      bpQ       <= BP_RESET;
      bpPend    <= 2'b00;
      pendValid <= 1'b0;
    end else begin
      if (strobe.clrWen)      wenQ <= 1'b0;
      else if (strobe.setWen) wenQ <= 1'b1;
      if (strobe.capBp) begin
        bpPend    <= reqProtBits;
        pendValid <= 1'b1;
      end else if (strobe.commitBp && pendValid) begin
        bpQ       <= bpPend;
        pendValid <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bpQ)
      2'b00:   inFence = 1'b0;
      2'b01:   inFence = (reqAddr >= QUARTER_BASE);
      2'b10:   inFence = (reqAddr >= HALF_BASE);
      default: inFence = 1'b1;
    endcase
  end

  always_comb begin
    if (progBusy) begin
      statusByte = 8'hFF;
    end else begin
      statusByte                        = 8'h00;
      statusByte[STS_BP_HI:STS_BP_LO]   = bpQ;
      statusByte[STS_WEN_BIT]           = wenQ;
      statusByte[STS_BUSY_BIT]          = 1'b0;
    end
  end

  // R8: completion always leaves the latch clear
  p_done_clears_wen_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitBp |=> !wenQ);
  // R7 / R9: the level only moves on a completion
  p_bp_only_on_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitBp |=> $stable(bpQ));

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      writeProtN,
  input  logic      cmdEnable,
  input  logic      cmdDisable,
  input  logic      reqArrayWr,
  input  logic      reqStatusWr,
  input  logic      progBusy,
  input  logic      progDone,
  input  logic      wenQ,
  input  logic      inFence,
  output wpStrobe_t strobe,
  output logic      grantArray,
  output logic      grantStatus
);

  logic idleOk;
  logic allowBase;
  logic arrOk;
  logic stsOk;

  assign idleOk    = !progBusy;
  assign allowBase = writeProtN && wenQ;
  assign arrOk     = idleOk && reqArrayWr && allowBase && !inFence;
  assign stsOk     = idleOk && reqStatusWr && !reqArrayWr && allowBase;

  always_comb begin
    strobe.setWen   = idleOk && cmdEnable;
    strobe.clrWen   = progDone || (idleOk && cmdDisable);
    strobe.capBp    = stsOk;
    strobe.commitBp = progDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantArray  <= 1'b0;
      grantStatus <= 1'b0;
    end else begin
      grantArray  <= arrOk;
      grantStatus <= stsOk;
    end
  end

  // R5: never two grants together
  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(grantArray && grantStatus));
  // R5 / R7: a grant needs the pin and the latch one cycle earlier
  p_grant_permitted_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grantArray || grantStatus) |-> $past(writeProtN && wenQ));
  // R6: an array grant never targets the fence
  p_grant_outside_fence_r6: assert property (@(posedge clk) disable iff (!rstN)
    grantArray |-> !$past(inFence));
  // R10: no grant for a request made while busy
  p_grant_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (grantArray || grantStatus) |-> !$past(progBusy));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter logic [1:0] BP_RESET = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeProtN,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              reqArrayWr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStatusWr,
  input  logic [1:0]        reqProtBits,
  input  logic              progBusy,
  input  logic              progDone,
  output logic              grantArray,
  output logic              grantStatus,
  output logic [7:0]        statusByte
);

  wpStrobe_t strobe;
  logic      wenQ;
  logic      inFence;

  wp_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .writeProtN  (writeProtN),
    .cmdEnable   (cmdEnable),
    .cmdDisable  (cmdDisable),
    .reqArrayWr  (reqArrayWr),
    .reqStatusWr (reqStatusWr),
    .progBusy    (progBusy),
    .progDone    (progDone),
    .wenQ        (wenQ),
    .inFence     (inFence),
    .strobe      (strobe),
    .grantArray  (grantArray),
    .grantStatus (grantStatus)
  );

  wp_datapath #(
    .ADDR_W   (ADDR_W),
    .BP_RESET (BP_RESET)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqProtBits (reqProtBits),
    .progBusy    (progBusy),
    .wenQ        (wenQ),
    .inFence     (inFence),
    .statusByte  (statusByte)
  );

  // R4: busy masks the status byte
  p_busy_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |-> (statusByte == 8'hFF));

endmodule

// File: tb/test_wp_guard.sv
module test_wp_guard;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       writeProtN = 1'b1;
  logic       cmdEnable = 1'b0;
  logic       cmdDisable = 1'b0;
  logic       reqArrayWr = 1'b0;
  logic [8:0] reqAddr = '0;
  logic       reqStatusWr = 1'b0;
  logic [1:0] reqProtBits = '0;
  logic       progBusy = 1'b0;
  logic       progDone = 1'b0;
  logic       grantArray;
  logic       grantStatus;
  logic [7:0] statusByte;

  always #10 clk = ~clk;

  wp_guard i_wp_guard (
    .clk(clk), .rstN(rstN), .writeProtN(writeProtN),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .reqArrayWr(reqArrayWr), .reqAddr(reqAddr),
    .reqStatusWr(reqStatusWr), .reqProtBits(reqProtBits),
    .progBusy(progBusy), .progDone(progDone),
    .grantArray(grantArray), .grantStatus(grantStatus),
    .statusByte(statusByte)
  );

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    logic  expArr;
    logic  expSts;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as grant slots come due
  always @(negedge clk) begin : monitor
    exp_t e;
    if (sbq.size() > 0 && sbq[0].due == cycleCnt) begin
      e = sbq.pop_front();
      check1({e.tag, " grantArray"}, grantArray, e.expArr);
      check1({e.tag, " grantStatus"}, grantStatus, e.expSts);
    end else if (rstN && (grantArray || grantStatus)) begin
      checks++;
      errors++;
      $display("FAIL R5 unexpected grant: got %0b%0b expected 00", grantArray, grantStatus);
    end
  end

  task automatic reqArray(logic [8:0] addr, logic expGrant, string tag);
    exp_t e;
    @(negedge clk);
    reqAddr    = addr;
    reqArrayWr = 1'b1;
    e.due = cycleCnt + 1; e.expArr = expGrant; e.expSts = 1'b0; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    reqArrayWr = 1'b0;
  endtask

  task automatic reqStatus(logic [7:0] dataByte, logic expGrant, string tag);
    exp_t e;
    @(negedge clk);
    reqProtBits = dataByte[3:2];
    reqStatusWr = 1'b1;
    e.due = cycleCnt + 1; e.expArr = 1'b0; e.expSts = expGrant; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    reqStatusWr = 1'b0;
  endtask

  task automatic pulseEnable();
    @(negedge clk); cmdEnable = 1'b1;
    @(negedge clk); cmdEnable = 1'b0;
  endtask

  task automatic pulseDisable();
    @(negedge clk); cmdDisable = 1'b1;
    @(negedge clk); cmdDisable = 1'b0;
  endtask

  // sequencer model: busy for some cycles, then a completion pulse
  task automatic doProgram(int n);
    @(negedge clk); progBusy = 1'b1;
    @(negedge clk);
    check8("R4 busy status", statusByte, 8'hFF);
    repeat (n) @(negedge clk);
    progDone = 1'b1;
    @(negedge clk);
    progDone = 1'b0;
    progBusy = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check8("R1 reset status", statusByte, 8'h00);

    pulseEnable();
    check8("R2 enable", statusByte, 8'h02);
    pulseDisable();
    check8("R2 disable", statusByte, 8'h00);

    reqArray(9'h010, 1'b0, "R9 no latch");
    check8("R9 state kept", statusByte, 8'h00);

    pulseEnable();
    writeProtN = 1'b0;
    reqArray(9'h010, 1'b0, "R5 pin low array");
    reqStatus(8'h0C, 1'b0, "R9 pin low status");
    check8("R9 latch and level kept", statusByte, 8'h02);
    writeProtN = 1'b1;

    reqArray(9'h1FF, 1'b1, "R5 level00 top");
    doProgram(4);
    check8("R8 latch cleared", statusByte, 8'h00);

    // busy without completion: commands must vanish
    @(negedge clk); progBusy = 1'b1;
    pulseEnable();
    reqArray(9'h000, 1'b0, "R10 busy array");
    reqStatus(8'h04, 1'b0, "R10 busy status");
    @(negedge clk); progBusy = 1'b0;
    @(negedge clk);
    check8("R10 enable ignored", statusByte, 8'h00);

    pulseEnable();
    @(negedge clk); progBusy = 1'b1;
    pulseDisable();
    @(negedge clk); progBusy = 1'b0;
    @(negedge clk);
    check8("R10 disable ignored", statusByte, 8'h02);

    reqStatus(8'h04, 1'b1, "R7 set level01");
    doProgram(3);
    check8("R7 R3 level01", statusByte, 8'h04);

    pulseEnable();
    check8("R3 layout", statusByte, 8'h06);
    reqArray(9'h180, 1'b0, "R6 level01 fenced");
    check8("R9 after fence", statusByte, 8'h06);
    reqArray(9'h17F, 1'b1, "R6 level01 open");
    doProgram(2);
    check8("R8 after array", statusByte, 8'h04);

    pulseEnable();
    reqStatus(8'h0B, 1'b1, "R7 set level10");
    doProgram(2);
    check8("R7 level10", statusByte, 8'h08);

    pulseEnable();
    reqArray(9'h100, 1'b0, "R6 level10 fenced");
    reqArray(9'h0FF, 1'b1, "R6 level10 open");
    doProgram(2);
    check8("R8 level10 done", statusByte, 8'h08);

    pulseEnable();
    reqStatus(8'hFC, 1'b1, "R7 set level11");
    doProgram(2);
    check8("R7 level11", statusByte, 8'h0C);

    pulseEnable();
    check8("R3 level11 wen", statusByte, 8'h0E);
    reqArray(9'h000, 1'b0, "R6 level11 fenced");
    reqStatus(8'h00, 1'b1, "R7 status under level11");
    doProgram(2);
    check8("R7 level back to 00", statusByte, 8'h00);

    repeat (3) @(negedge clk);
    check1("R5 queue drained", sbq.size() == 0, 1'b1);
    done = 1'b1;
    finishRun();
  end

endmodule